// File: doc/BRIEF.md
# Serial ADC Read Controller

This block sits on the host side of a 12-bit successive-approximation converter that has a three-wire serial port. It produces the convert strobe and the shift clock, samples the converter's serial data line, and returns each 12-bit code with a one-cycle valid pulse. All timing counts in system clocks. The parameters set the acquisition window, the conversion window, the set-up gap between the convert line falling and the first shift-clock rise, the shift-clock half period and the number of shift clocks in a frame (12 to 16).

A request is taken only while the block is idle. In that state the convert line is high, so the converter sleeps, and the shift clock is low. The mode input is captured when the request is accepted. In wake-read mode (mode 0) the controller lowers the convert line and reads the code of the previous conversion. It then keeps the line low for the rest of the acquisition window and raises it for one conversion, which leaves the converter asleep. In low-latency mode (mode 1) the controller first acquires, converts and reads the fresh code. It then runs a dummy conversion so that the converter again sleeps with the convert line high.

Elaboration checks reject a frame length outside 12..16. They also reject a shift clock faster than 20 MHz and a set-up gap shorter than 16 ns, both computed from the system clock period parameter.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is asserted and right after it, conv_o is 1, sck_o is 0, busy_o is 0, valid_o is 0 and data_o is 0.
- R2: In mode 0 an accepted request drives conv_o low at the next clock edge. conv_o then stays low for exactly T_SETUP cycles before the shift clock starts.
- R3: A frame has exactly N_BITS shift-clock pulses. Each pulse is SCK_DIV cycles low followed by SCK_DIV cycles high. sck_o is 0 at all other times, and always while conv_o is 1.
- R4: sdo_i is sampled at each edge where sck_o rises. The first 12 samples form data_o, with the first sample in bit 11 and the twelfth in bit 0. Samples 13 to N_BITS have no effect on data_o.
- R5: valid_o is high for exactly one cycle per request, in the cycle right after the last shift-clock fall. data_o changes only together with valid_o.
- R6: In mode 0, after the frame, conv_o stays low until it has been low for max(T_SETUP+2·N_BITS·SCK_DIV+1, T_ACQ) cycles in total. It then goes high for T_CONV cycles, and the block returns to idle with conv_o still high.
- R7: In mode 1 the sequence is: conv_o low for T_ACQ cycles, high for T_CONV cycles, low for T_SETUP cycles plus the frame, then high for a dummy conversion of T_CONV cycles. The block then returns to idle with conv_o high. The code returned is the one latched at the first rise of conv_o.
- R8: busy_o is 1 from the edge that accepts a request through the last cycle of the final conversion. A request seen while busy_o is 1 is ignored. busy_o is 0 only in idle.
- R9: mode_i is sampled only at the edge that accepts a request. Changes to mode_i during a transaction have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Sample request, taken only when idle |
| mode_i | input | 1 | 0 = read on wake, 1 = low-latency read with dummy conversion |
| conv_o | output | 1 | Convert strobe to the converter |
| sck_o | output | 1 | Shift clock to the converter |
| sdo_i | input | 1 | Serial data from the converter |
| data_o | output | 12 | Last assembled 12-bit code |
| valid_o | output | 1 | One-cycle pulse when data_o is updated |
| busy_o | output | 1 | Transaction in progress |

## Verification
The bound checker watches these rules on every cycle: the shift clock stays quiet while the convert line is high, the high width of each pulse, the set-up gap before the first rise, the one-cycle valid pulse, that data holds between pulses, the pulse count per frame and the idle levels. Other behaviours can only be shown by the bench scenarios comparing against a cycle reference. These include the exact cycle of every convert-line edge in each mode, which conversion's code a given mode returns, and whether the acquisition window or the frame length sets the low time. They also include that trailing bits driven to 1 leave the code unchanged, and that requests and mode changes during a transaction are dropped.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

   localparam int RES_W = 12;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ACQ,
      ST_CNV,
      ST_SETUP,
      ST_SHIFT
   } rd_state_e;

endpackage

// File: rtl/adc_rd_sclk.sv
module adc_rd_sclk #(
   parameter int SCK_DIV = 3,
   parameter int N_BITS  = 16,
   parameter int IDX_W   = $clog2(N_BITS + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   output logic             sck_o,
   output logic             rise_o,
   output logic             last_fall_o,
   output logic [IDX_W-1:0] idx_o
);

   localparam int PH_W = $clog2(SCK_DIV + 1);

   logic [PH_W-1:0]  ph_q;
   logic             sck_q;
   logic [IDX_W-1:0] nrise_q;
   logic             ph_end;

   assign ph_end      = (ph_q == PH_W'(SCK_DIV - 1));
   assign rise_o      = run_i & ph_end & ~sck_q;
   assign last_fall_o = run_i & ph_end & sck_q & (nrise_q == IDX_W'(N_BITS));
   assign sck_o       = sck_q;
   assign idx_o       = nrise_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni || !run_i) begin
         ph_q    <= '0;
         sck_q   <= 1'b0;
         nrise_q <= '0;
      end else if (ph_end) begin
         ph_q  <= '0;
         sck_q <= ~sck_q;
         if (!sck_q) nrise_q <= nrise_q + 1'b1;
      end else begin
         ph_q <= ph_q + 1'b1;
      end
   end

endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture #(
   parameter int N_BITS = 16,
   parameter int RES_W  = 12,
   parameter int IDX_W  = $clog2(N_BITS + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             rise_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic             sdo_i,
   input  logic             end_i,
   output logic [RES_W-1:0] data_o,
   output logic             valid_o
);

   logic             take;
   logic [RES_W-1:0] sh_q;

   generate
      if (N_BITS > RES_W) begin : g_trim
         assign take = rise_i & (idx_i < IDX_W'(RES_W));
      end else begin : g_exact
         logic unused_idx;
         assign unused_idx = ^idx_i;
         assign take = rise_i;
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         sh_q    <= '0;
         data_o  <= '0;
         valid_o <= 1'b0;
      end else begin
         if (take) sh_q <= {sh_q[RES_W-2:0], sdo_i};
         valid_o <= end_i;
         if (end_i) data_o <= sh_q;
      end
   end

endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
   import adc_rd_pkg::*;
#(
   parameter int CLK_PS  = 10000,
   parameter int T_ACQ   = 50,
   parameter int T_CONV  = 150,
   parameter int T_SETUP = 2,
   parameter int SCK_DIV = 3,
   parameter int N_BITS  = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             req_i,
   input  logic             mode_i,
   output logic             conv_o,
   output logic             sck_o,
   input  logic             sdo_i,
   output logic [RES_W-1:0] data_o,
   output logic             valid_o,
   output logic             busy_o
);

   localparam int IDX_W  = $clog2(N_BITS + 1);
   localparam int WIN    = (T_CONV > T_SETUP) ? T_CONV : T_SETUP;
   localparam int CNT_W  = $clog2(WIN + 1);
   localparam int LOW_W  = $clog2(T_ACQ + 1);

   generate
      if (N_BITS < RES_W || N_BITS > 16) begin : g_bad_bits
         $error("frame length must be 12..16 shift clocks");
      end
      if (SCK_DIV < 1 || 2 * SCK_DIV * CLK_PS < 50000) begin : g_bad_sck
         $error("shift clock faster than 20 MHz");
      end
      if (T_SETUP < 1 || T_SETUP * CLK_PS < 16000) begin : g_bad_setup
         $error("set-up gap shorter than 16 ns");
      end
      if (T_ACQ < 1 || T_CONV < 1) begin : g_bad_win
         $error("acquisition and conversion windows need at least one cycle");
      end
   endgenerate

   rd_state_e        st_q, st_nxt;
   logic [CNT_W-1:0] cnt_q;
   logic [LOW_W-1:0] low_q;
   logic             conv_q, conv_nxt;
   logic             busy_q;
   logic             mode_q;
   logic             rd_done_q;
   logic             accept;

   logic             sck_w, rise_w, last_fall_w;
   logic [IDX_W-1:0] idx_w;

   assign accept = (st_q == ST_IDLE) & req_i;

   always_comb begin
      st_nxt = st_q;
      unique case (st_q)
         ST_IDLE:  if (req_i) st_nxt = mode_i ? ST_ACQ : ST_SETUP;
         ST_ACQ:   if (low_q >= LOW_W'(T_ACQ)) st_nxt = ST_CNV;
         ST_CNV:   if (cnt_q == CNT_W'(T_CONV - 1))
                      st_nxt = rd_done_q ? ST_IDLE : ST_SETUP;
         ST_SETUP: if (cnt_q == CNT_W'(T_SETUP - 1)) st_nxt = ST_SHIFT;
         ST_SHIFT: if (last_fall_w) st_nxt = mode_q ? ST_CNV : ST_ACQ;
         default:  st_nxt = ST_IDLE;
      endcase
   end

   assign conv_nxt = (st_nxt == ST_IDLE) || (st_nxt == ST_CNV);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         st_q      <= ST_IDLE;
         cnt_q     <= '0;
         low_q     <= '0;
         conv_q    <= 1'b1;
         busy_q    <= 1'b0;
         mode_q    <= 1'b0;
         rd_done_q <= 1'b0;
      end else begin
         st_q   <= st_nxt;
         conv_q <= conv_nxt;
         busy_q <= (st_nxt != ST_IDLE);
         if (st_nxt != st_q) cnt_q <= '0;
         else if (st_q == ST_CNV || st_q == ST_SETUP) cnt_q <= cnt_q + 1'b1;
         if (!conv_nxt) begin
            if (conv_q) low_q <= LOW_W'(1);
            else if (low_q != LOW_W'(T_ACQ)) low_q <= low_q + 1'b1;
         end
         if (accept) begin
            mode_q    <= mode_i;
            rd_done_q <= 1'b0;
         end else if (last_fall_w) begin
            rd_done_q <= 1'b1;
         end
      end
   end

   adc_rd_sclk #(
      .SCK_DIV (SCK_DIV),
      .N_BITS  (N_BITS),
      .IDX_W   (IDX_W)
   ) u_sclk (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .run_i       (st_q == ST_SHIFT),
      .sck_o       (sck_w),
      .rise_o      (rise_w),
      .last_fall_o (last_fall_w),
      .idx_o       (idx_w)
   );

   adc_rd_capture #(
      .N_BITS (N_BITS),
      .RES_W  (RES_W),
      .IDX_W  (IDX_W)
   ) u_cap (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .rise_i  (rise_w),
      .idx_i   (idx_w),
      .sdo_i   (sdo_i),
      .end_i   (last_fall_w),
      .data_o  (data_o),
      .valid_o (valid_o)
   );

   assign conv_o = conv_q;
   assign sck_o  = sck_w;
   assign busy_o = busy_q;

endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk #(
   parameter int T_SETUP = 2,
   parameter int SCK_DIV = 3,
   parameter int N_BITS  = 16
) (
   input logic        clk_i,
   input logic        rst_ni,
   input logic        conv_o,
   input logic        sck_o,
   input logic        busy_o,
   input logic        valid_o,
   input logic [11:0] data_o
);

   localparam int HI_W = $clog2(SCK_DIV + 2);
   localparam int RC_W = $clog2(N_BITS + 2);

   logic [HI_W-1:0] sck_hi_q;
   logic [15:0]     sck_lo_q;
   logic [15:0]     conv_lo_q;
   logic [RC_W-1:0] rises_q;
   logic            sck_d_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         sck_hi_q  <= '0;
         sck_lo_q  <= '0;
         conv_lo_q <= '0;
         rises_q   <= '0;
         sck_d_q   <= 1'b0;
      end else begin
         sck_d_q   <= sck_o;
         sck_hi_q  <= !sck_o ? '0 : (&sck_hi_q ? sck_hi_q : sck_hi_q + 1'b1);
         sck_lo_q  <= sck_o ? '0 : (&sck_lo_q ? sck_lo_q : sck_lo_q + 1'b1);
         conv_lo_q <= conv_o ? '0 : (&conv_lo_q ? conv_lo_q : conv_lo_q + 1'b1);
         if (!busy_o) rises_q <= '0;
         else if (sck_o && !sck_d_q) rises_q <= rises_q + 1'b1;
      end
   end

   AST_SCK_QUIET_CONV: assert property (@(posedge clk_i) disable iff (!rst_ni)
      conv_o |-> !sck_o); // R3
   AST_SCK_HIGH_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sck_o && $past(sck_o)) |-> (sck_hi_q == HI_W'(SCK_DIV))); // R3
   AST_SCK_LOW_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sck_o) |-> (sck_lo_q >= 16'(SCK_DIV))); // R3
   AST_SETUP_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sck_o) |-> (conv_lo_q >= 16'(T_SETUP))); // R2
   AST_FRAME_PULSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> (rises_q == RC_W'(N_BITS))); // R3
   AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |=> !valid_o); // R5
   AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_o |-> $stable(data_o)); // R5
   AST_IDLE_LEVELS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> (conv_o && !sck_o && !valid_o)); // R8
   AST_CONV_FALL_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(conv_o) |-> busy_o); // R8

endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(
   .T_SETUP (T_SETUP),
   .SCK_DIV (SCK_DIV),
   .N_BITS  (N_BITS)
) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .conv_o  (conv_o),
   .sck_o   (sck_o),
   .busy_o  (busy_o),
   .valid_o (valid_o),
   .data_o  (data_o)
);

// File: tb/adc_rd_ctrl_tb_top.sv
module adc_rd_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int P_ACQ   = 100;
   localparam int P_CONV  = 20;
   localparam int P_SETUP = 2;
   localparam int P_DIV   = 3;
   localparam int P_BITS  = 14;
   localparam int WD_LIMIT = 50000;
   localparam logic [3:0] IDLE_V = 4'b1000; // {conv, sck, busy, valid}

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic        mode = 1'b0;
   logic        sdo = 1'b0;
   logic        conv, sck, busy, valid;
   logic [11:0] data;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   adc_rd_ctrl #(
      .CLK_PS  (10000),
      .T_ACQ   (P_ACQ),
      .T_CONV  (P_CONV),
      .T_SETUP (P_SETUP),
      .SCK_DIV (P_DIV),
      .N_BITS  (P_BITS)
   ) dut_i (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .req_i   (req),
      .mode_i  (mode),
      .conv_o  (conv),
      .sck_o   (sck),
      .sdo_i   (sdo),
      .data_o  (data),
      .valid_o (valid),
      .busy_o  (busy)
   );

   // converter model
   logic [11:0] ain = 12'h000;
   logic [11:0] adc_code = 12'h5A5;
   logic        trail_fill = 1'b0;
   int          adc_idx = 0;

   always @(posedge conv) if (rst_n) begin
      adc_code = ain;
      sdo = 1'b0;
   end
   always @(negedge conv) if (rst_n) begin
      adc_idx = 0;
      sdo = adc_code[11];
   end
   always @(negedge sck) if (rst_n && !conv) begin
      adc_idx++;
      sdo = (adc_idx < 12) ? adc_code[11 - adc_idx] : trail_fill;
   end

   // cycle reference: expected {conv, sck, busy, valid} per cycle
   logic [3:0]  exp_q[$];
   logic [3:0]  cur = IDLE_V;
   logic [11:0] m_code = 12'h5A5;
   logic [11:0] exp_data = 12'h000;

   function automatic void push_n(int n, logic [3:0] v);
      for (int i = 0; i < n; i++) exp_q.push_back(v);
   endfunction

   function automatic void push_frame();
      for (int b = 0; b < P_BITS; b++) begin
         push_n(P_DIV, 4'b0010);
         push_n(P_DIV, 4'b0110);
      end
   endfunction

   function automatic void fill(logic m);
      int frame_low;
      int tail;
      if (m) begin
         push_n(P_ACQ, 4'b0010);
         push_n(P_CONV, 4'b1010);
         push_n(P_SETUP, 4'b0010);
         push_frame();
         exp_q.push_back(4'b1011);
         push_n(P_CONV - 1, 4'b1010);
      end else begin
         push_n(P_SETUP, 4'b0010);
         push_frame();
         frame_low = P_SETUP + 2 * P_BITS * P_DIV;
         tail = ((frame_low + 1 > P_ACQ) ? frame_low + 1 : P_ACQ) - frame_low;
         exp_q.push_back(4'b0011);
         push_n(tail - 1, 4'b0010);
         push_n(P_CONV, 4'b1010);
      end
   endfunction

   always @(posedge clk) begin
      logic prev_conv;
      if (!rst_n) begin
         exp_q.delete();
         cur = IDLE_V;
         exp_data = 12'h000;
      end else begin
         if (cur == IDLE_V && req) fill(mode);
         prev_conv = cur[3];
         cur = (exp_q.size() > 0) ? exp_q.pop_front() : IDLE_V;
         if (cur[0]) exp_data = m_code;
         if (!prev_conv && cur[3]) m_code = ain;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
      end
   endtask

   always @(negedge clk) if (rst_n) begin
      chk(conv === cur[3], "R2/R6/R7 conv_o", conv, cur[3]);
      chk(sck === cur[2], "R3 sck_o", sck, cur[2]);
      chk(busy === cur[1], "R8 busy_o", busy, cur[1]);
      chk(valid === cur[0], "R5 valid_o", valid, cur[0]);
      chk(data === exp_data, "R4 data_o", data, exp_data);
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > WD_LIMIT) begin
         n_fail++;
         $display("FAIL R8 watchdog busy_o actual=%0d expected=0", busy);
         summary();
         $finish;
      end
   end

   // one transaction: optional poke while busy (R8), mode flipped after accept (R9)
   task automatic txn(input logic m, input logic [11:0] a, input logic [11:0] expv,
                      input logic trail, input bit poke);
      int guard;
      ain = a;
      trail_fill = trail;
      @(negedge clk);
      req = 1'b1;
      mode = m;
      @(negedge clk);
      req = 1'b0;
      mode = ~m;
      if (poke) begin
         repeat (7) @(negedge clk);
         req = 1'b1;
         @(negedge clk);
         req = 1'b0;
      end
      guard = 0;
      while (valid !== 1'b1 && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      chk(valid === 1'b1 && data === expv, "R4 returned code", data, expv);
      guard = 0;
      while (busy !== 1'b0 && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      chk(busy === 1'b0 && conv === 1'b1, "R6/R7 idle with conv_o high", conv, 1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(conv === 1'b1, "R1 conv_o in reset", conv, 1);
      chk(sck === 1'b0, "R1 sck_o in reset", sck, 0);
      chk(busy === 1'b0 && valid === 1'b0, "R1 busy/valid in reset", {busy, valid}, 0);
      chk(data === 12'h000, "R1 data_o in reset", data, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      // R2 R6: wake-read returns the code held from before
      txn(1'b0, 12'hABC, 12'h5A5, 1'b0, 1'b1);
      // R7: low-latency returns the fresh code
      txn(1'b1, 12'h123, 12'h123, 1'b0, 1'b1);
      // R6: dummy conversion latched 123, so wake-read returns it
      txn(1'b0, 12'hFFF, 12'h123, 1'b0, 1'b0);
      // R4: trailing bits driven to 1 are dropped
      txn(1'b0, 12'h000, 12'hFFF, 1'b1, 1'b0);
      txn(1'b1, 12'h801, 12'h801, 1'b1, 1'b1);
      // back-to-back, mode toggling (R9)
      txn(1'b1, 12'h7FE, 12'h7FE, 1'b0, 1'b0);
      txn(1'b0, 12'h3C3, 12'h7FE, 1'b1, 1'b0);
      txn(1'b1, 12'h001, 12'h001, 1'b0, 1'b1);
      repeat (10) @(negedge clk);
      chk(busy === 1'b0 && sck === 1'b0, "R8 quiet idle", {busy, sck}, 0);
      summary();
      $finish;
   end

endmodule